// File: doc/BRIEF.md
# Four-Operand Carry-Save Adder

This block adds four unsigned operands of equal width N (named A, B, E and F) in a single pass of combinational logic and returns their exact total on N+2 bits. Carries are not propagated while the operands are being combined. A first row of 3:2 compressors reduces B, E and F to a partial-sum vector and a carry vector. A second row merges that pair with A. Only after that does one conventional two-operand adder resolve the carries.

Both compressor rows expose their sum and carry vectors at the ports, so each stage can be checked on its own. A parameter selects the final adder. One choice is a ripple chain of half and full adder cells. The other is a carry-lookahead adder whose carries are each formed as a flat sum of products. The block has no clock and no state. N defaults to 4, and 16 is the other width the block is intended for.

Top module: `csa4_adder`

## Requirements
- R1: `sum` always equals A+B+E+F computed at N+2 bits. It therefore also equals the chained total ((A+B)+E)+F and the paired total (A+B)+(E+F).
- R2: For each column i of the first row, let k be the count of ones among B[i], E[i] and F[i]. Then `lvl1_sum[i]` is k mod 2 and `lvl1_carry[i]` is k div 2. Bit i of `lvl1_carry` has weight 2^(i+1).
- R3: The second row handles its columns as follows. Column 0 half-adds `lvl1_sum[0]` and A[0]. Each column i from 1 to N-1 full-adds `lvl1_sum[i]`, A[i] and `lvl1_carry[i-1]`. Column N passes `lvl1_carry[N-1]` through to `lvl2_sum[N]`. Bit i of `lvl2_carry` has weight 2^(i+1).
- R4: `sum[0]` equals `lvl2_sum[0]`, because the final adder takes no carry into bit 0.
- R5: The final adder adds `lvl2_sum[N:1]` to `lvl2_carry` and writes the result to `sum[N:1]`. Its carry-out is `sum[N+1]`.
- R6: The ripple and lookahead variants of the final adder give identical `sum` for identical operands.
- R7: The block is correct at N=4 over all 65,536 operand combinations, and at N=16.
- R8: When all four operands are all ones, `sum` is 4*(2^N-1), which sets `sum[N+1]`.
- R9: Every output is a pure function of the four operands. No state is held, so an operand change is reflected at the outputs before the next clock edge of the surrounding logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | N | Operand A, merged at the second row |
| b | input | N | Operand B, first row |
| e | input | N | Operand E, first row |
| f | input | N | Operand F, first row |
| lvl1_sum | output | N | First-row partial sum bits |
| lvl1_carry | output | N | First-row carries, bit i weighted 2^(i+1) |
| lvl2_sum | output | N+1 | Second-row partial sum bits |
| lvl2_carry | output | N | Second-row carries, bit i weighted 2^(i+1) |
| sum | output | N+2 | Final total |

## Verification
The hardest condition to reach is a carry generated at column 0 that rides through every column of the final adder into `sum[N+1]`. Reaching it needs operand patterns that fill both compressor rows with ones at once. At N=4 the stimulus covers this by walking all 65,536 operand combinations. At N=16 the random vectors are joined by all-ones, alternating-bit and single-operand-maximum patterns, and by walking-one patterns that place one carry at each column. Each vector is applied to both final-adder variants at the same time, so their results can be compared directly.

// File: rtl/csa4_pkg.sv
package csa4_pkg;
  typedef enum logic {
    CPA_RIPPLE    = 1'b0,
    CPA_LOOKAHEAD = 1'b1
  } cpa_kind_e;
endpackage

// File: rtl/csa4_cells.sv
// Two-level bit cells used by every row of the adder.
module csa4_full_add (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ z;
  assign co = (x & y) | (x & z) | (y & z);
endmodule

module csa4_half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic co
);
  assign s  = x ^ y;
  assign co = x & y;
endmodule

// File: rtl/csa4_compress_row.sv
// First row: three full-width operands, one full adder per column.
module csa4_compress_row #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  for (genvar i = 0; i < W; i++) begin : g_col
    csa4_full_add u_fa (.x(x[i]), .y(y[i]), .z(z[i]), .s(s[i]), .co(c[i]));
  end
endmodule

// File: rtl/csa4_merge_row.sv
// Second row: partial sum, carries shifted one column left, and one operand.
// Column 0 has two live inputs, column W has only the top carry.
module csa4_merge_row #(
  parameter int W = 4
) (
  input  logic [W-1:0] ps,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] op,
  output logic [W:0]   s,
  output logic [W-1:0] c
);
  csa4_half_add u_ha0 (.x(ps[0]), .y(op[0]), .s(s[0]), .co(c[0]));
  for (genvar i = 1; i < W; i++) begin : g_col
    csa4_full_add u_fa (.x(ps[i]), .y(op[i]), .z(pc[i-1]), .s(s[i]), .co(c[i]));
  end
  assign s[W] = pc[W-1];
endmodule

// File: rtl/csa4_cpa.sv
// Final carry-propagate adder, two operands, no carry-in.
module csa4_cpa #(
  parameter int                  W    = 4,
  parameter csa4_pkg::cpa_kind_e KIND = csa4_pkg::CPA_RIPPLE
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         co
);
  if (KIND == csa4_pkg::CPA_LOOKAHEAD) begin : g_cla
    logic [W-1:0] gen_v;
    logic [W-1:0] prop_v;
    logic [W:0]   cl;
    logic         term;
    logic         acc;
    assign gen_v  = x & y;
    assign prop_v = x ^ y;
    // Each carry is a flat OR of generate terms gated by the propagates above.
    always_comb begin
      cl   = '0;
      term = 1'b0;
      acc  = 1'b0;
      for (int i = 0; i < W; i++) begin
        acc = 1'b0;
        for (int j = 0; j <= i; j++) begin
          term = gen_v[j];
          for (int k = j + 1; k <= i; k++) term = term & prop_v[k];
          acc = acc | term;
        end
        cl[i+1] = acc;
      end
    end
    assign s  = prop_v ^ cl[W-1:0];
    assign co = cl[W];
  end else begin : g_ripple
    logic [W:1] cy;
    csa4_half_add u_ha0 (.x(x[0]), .y(y[0]), .s(s[0]), .co(cy[1]));
    for (genvar i = 1; i < W; i++) begin : g_col
      csa4_full_add u_fa (.x(x[i]), .y(y[i]), .z(cy[i]), .s(s[i]), .co(cy[i+1]));
    end
    assign co = cy[W];
  end
endmodule

// File: rtl/csa4_adder.sv
module csa4_adder #(
  parameter int                  N    = 4,
  parameter csa4_pkg::cpa_kind_e KIND = csa4_pkg::CPA_RIPPLE
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] e,
  input  logic [N-1:0] f,
  output logic [N-1:0] lvl1_sum,
  output logic [N-1:0] lvl1_carry,
  output logic [N:0]   lvl2_sum,
  output logic [N-1:0] lvl2_carry,
  output logic [N+1:0] sum
);
  logic [N-1:0] upper;
  logic         cout;

  csa4_compress_row #(.W(N)) u_row1 (
    .x(b), .y(e), .z(f), .s(lvl1_sum), .c(lvl1_carry)
  );

  csa4_merge_row #(.W(N)) u_row2 (
    .ps(lvl1_sum), .pc(lvl1_carry), .op(a), .s(lvl2_sum), .c(lvl2_carry)
  );

  csa4_cpa #(.W(N), .KIND(KIND)) u_cpa (
    .x(lvl2_sum[N:1]), .y(lvl2_carry), .s(upper), .co(cout)
  );

  assign sum = {cout, upper, lvl2_sum[0]};
endmodule

// File: rtl/csa4_adder_chk.sv
module csa4_adder_chk #(
  parameter int N = 4
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [N-1:0] e,
  input logic [N-1:0] f,
  input logic [N-1:0] lvl1_sum,
  input logic [N-1:0] lvl1_carry,
  input logic [N:0]   lvl2_sum,
  input logic [N-1:0] lvl2_carry,
  input logic [N+1:0] sum
);
  localparam int SW = N + 2;
  logic [SW-1:0] total_in;
  logic [SW-1:0] row1_in;
  logic [SW-1:0] row1_val;
  logic [SW-1:0] row2_val;
  logic [N:0]    fin_val;

  always_comb begin
    total_in = SW'(a) + SW'(b) + SW'(e) + SW'(f);
    row1_in  = SW'(b) + SW'(e) + SW'(f);
    row1_val = SW'(lvl1_sum) + (SW'(lvl1_carry) << 1);
    row2_val = SW'(lvl2_sum) + (SW'(lvl2_carry) << 1);
    fin_val  = (N+1)'(lvl2_sum[N:1]) + (N+1)'(lvl2_carry);
    if (!$isunknown({a, b, e, f, lvl1_sum, lvl1_carry, lvl2_sum, lvl2_carry, sum})) begin
      assert_total_R1: assert (sum == total_in)
        else $error("total mismatch");
      assert_row1_weight_R2: assert (row1_val == row1_in)
        else $error("first row loses weight");
      assert_row2_weight_R3: assert (row2_val == row1_val + SW'(a))
        else $error("second row loses weight");
      assert_row2_top_R3: assert (lvl2_sum[N] == lvl1_carry[N-1])
        else $error("second row top column");
      assert_lsb_R4: assert (sum[0] == lvl2_sum[0])
        else $error("bit 0 mismatch");
      assert_final_R5: assert (sum[N+1:1] == fin_val)
        else $error("final adder mismatch");
    end
  end
endmodule

bind csa4_adder csa4_adder_chk #(.N(N)) u_chk (
  .a(a), .b(b), .e(e), .f(f),
  .lvl1_sum(lvl1_sum), .lvl1_carry(lvl1_carry),
  .lvl2_sum(lvl2_sum), .lvl2_carry(lvl2_carry), .sum(sum)
);

// File: tb/test_csa4_adder.sv
module test_csa4_adder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  a4, b4, e4, f4;
  logic [15:0] a16, b16, e16, f16;

  logic [3:0]  r4_s1, r4_c1, r4_c2, l4_s1, l4_c1, l4_c2;
  logic [4:0]  r4_s2, l4_s2;
  logic [5:0]  r4_sum, l4_sum;
  logic [15:0] r16_s1, r16_c1, r16_c2, l16_s1, l16_c1, l16_c2;
  logic [16:0] r16_s2, l16_s2;
  logic [17:0] r16_sum, l16_sum;

  csa4_adder #(.N(4), .KIND(csa4_pkg::CPA_RIPPLE)) i_csa4_adder (
    .a(a4), .b(b4), .e(e4), .f(f4), .lvl1_sum(r4_s1), .lvl1_carry(r4_c1),
    .lvl2_sum(r4_s2), .lvl2_carry(r4_c2), .sum(r4_sum));
  csa4_adder #(.N(4), .KIND(csa4_pkg::CPA_LOOKAHEAD)) i_csa4_adder_n4la (
    .a(a4), .b(b4), .e(e4), .f(f4), .lvl1_sum(l4_s1), .lvl1_carry(l4_c1),
    .lvl2_sum(l4_s2), .lvl2_carry(l4_c2), .sum(l4_sum));
  csa4_adder #(.N(16), .KIND(csa4_pkg::CPA_RIPPLE)) i_csa4_adder_n16r (
    .a(a16), .b(b16), .e(e16), .f(f16), .lvl1_sum(r16_s1), .lvl1_carry(r16_c1),
    .lvl2_sum(r16_s2), .lvl2_carry(r16_c2), .sum(r16_sum));
  csa4_adder #(.N(16), .KIND(csa4_pkg::CPA_LOOKAHEAD)) i_csa4_adder_n16la (
    .a(a16), .b(b16), .e(e16), .f(f16), .lvl1_sum(l16_s1), .lvl1_carry(l16_c1),
    .lvl2_sum(l16_s2), .lvl2_carry(l16_c2), .sum(l16_sum));

  task automatic check(input string req, input string who,
                       input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s %s actual=%0h expected=%0h", req, who, act, exp);
    end
  endtask

  // Column-by-column model of both compressor rows, from the requirements.
  task automatic model_rows(input int n, input logic [17:0] a, b, e, f,
                            output logic [17:0] s1, c1, s2, c2);
    int k;
    s1 = '0; c1 = '0; s2 = '0; c2 = '0;
    for (int i = 0; i < n; i++) begin
      k = int'(b[i]) + int'(e[i]) + int'(f[i]);
      s1[i] = k[0]; c1[i] = k[1];
    end
    k = int'(s1[0]) + int'(a[0]);
    s2[0] = k[0]; c2[0] = k[1];
    for (int i = 1; i < n; i++) begin
      k = int'(s1[i]) + int'(a[i]) + int'(c1[i-1]);
      s2[i] = k[0]; c2[i] = k[1];
    end
    s2[n] = c1[n-1];
  endtask

  task automatic check_unit(input string who, input int n,
                            input logic [17:0] a, b, e, f,
                            input logic [17:0] s1, c1, s2, c2, sm);
    logic [17:0] es1, ec1, es2, ec2, total, chain, paired;
    model_rows(n, a, b, e, f, es1, ec1, es2, ec2);
    total  = a + b + e + f;
    chain  = ((a + b) + e) + f;
    paired = (a + b) + (e + f);
    check("R2", {who, " lvl1_sum"}, s1, es1);
    check("R2", {who, " lvl1_carry"}, c1, ec1);
    check("R3", {who, " lvl2_sum"}, s2, es2);
    check("R3", {who, " lvl2_carry"}, c2, ec2);
    check("R1", {who, " sum"}, sm, total);
    check("R1", {who, " sum vs chain"}, sm, chain);
    check("R1", {who, " sum vs paired"}, sm, paired);
    check("R4", {who, " bit0"}, 18'(sm[0]), 18'(s2[0]));
    check("R5", {who, " top bit"}, 18'(sm[n+1]), 18'(total[n+1]));
  endtask

  task automatic apply4(input logic [15:0] v);
    @(posedge clk);
    {a4, b4, e4, f4} = v;
    @(negedge clk);
    check_unit("R7 n4 ripple", 4, 18'(a4), 18'(b4), 18'(e4), 18'(f4),
               18'(r4_s1), 18'(r4_c1), 18'(r4_s2), 18'(r4_c2), 18'(r4_sum));
    check_unit("R7 n4 lookahead", 4, 18'(a4), 18'(b4), 18'(e4), 18'(f4),
               18'(l4_s1), 18'(l4_c1), 18'(l4_s2), 18'(l4_c2), 18'(l4_sum));
    check("R6", "n4 ripple vs lookahead", 18'(r4_sum), 18'(l4_sum));
  endtask

  task automatic apply16(input logic [15:0] va, vb, ve, vf);
    @(posedge clk);
    a16 = va; b16 = vb; e16 = ve; f16 = vf;
    @(negedge clk);
    check_unit("R7 n16 ripple", 16, 18'(a16), 18'(b16), 18'(e16), 18'(f16),
               18'(r16_s1), 18'(r16_c1), 18'(r16_s2), 18'(r16_c2), r16_sum);
    check_unit("R7 n16 lookahead", 16, 18'(a16), 18'(b16), 18'(e16), 18'(f16),
               18'(l16_s1), 18'(l16_c1), 18'(l16_s2), 18'(l16_c2), l16_sum);
    check("R6", "n16 ripple vs lookahead", r16_sum, l16_sum);
  endtask

  initial begin
    a4 = '0; b4 = '0; e4 = '0; f4 = '0;
    a16 = '0; b16 = '0; e16 = '0; f16 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: zero operands give all-zero outputs (R1, R9).
    check("R1", "reset n4 sum", 18'(r4_sum), 18'd0);
    check("R9", "reset n16 sum", r16_sum, 18'd0);
    rst = 1'b0;

    // R9: an operand change is visible within the same cycle.
    @(posedge clk);
    a4 = 4'd1;
    #1;
    check("R9", "n4 same-cycle update", 18'(r4_sum), 18'd1);

    // R7: exhaustive at N=4.
    for (int v = 0; v < 65536; v++) apply4(v[15:0]);

    // R8: all ones at both widths.
    apply4(16'hFFFF);
    check("R8", "n4 all ones", 18'(r4_sum), 18'd60);
    check("R8", "n4 all ones top", 18'(r4_sum[5]), 18'd1);
    apply16(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    check("R8", "n16 all ones", r16_sum, 18'h3FFFC);
    check("R8", "n16 all ones lookahead", l16_sum, 18'h3FFFC);

    // Directed corners at N=16.
    apply16(16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555);
    apply16(16'hFFFF, 16'h0000, 16'h0000, 16'h0000);
    apply16(16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000);
    apply16(16'h0001, 16'hFFFF, 16'h0000, 16'h0000);
    for (int i = 0; i < 16; i++)
      apply16(16'h0001 << i, 16'hFFFF, 16'h0001 << i, 16'h0001 << i);

    // Random vectors at N=16.
    for (int v = 0; v < 10000; v++)
      apply16($urandom(), $urandom(), $urandom(), $urandom());

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule